// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt request lines and turns them into a single vector offered to a processor core. Each line has its own trigger mode, enable and priority. A request is captured in a per-line pending bit. The controller offers the most urgent pending, enabled line whose priority is strictly above the handler that is currently executing. The core takes the offered vector with an acknowledge pulse and later closes the handler with an end-of-handler pulse.

A global mask input models a critical section. While it is high, nothing is offered, but requests keep arriving and are latched. When the mask drops, the latched lines are released one after another in priority order.

An active-priority stack records the priority of every handler that has been entered and not yet closed. A more urgent request can therefore interrupt a running handler. Closing the inner handler brings back the outer handler's priority for later comparisons.

Top module: `prio_nest_irq_ctrl`

## Requirements
- R1: After reset no line is pending, `irq_valid_o` is low, `nest_depth_o` is 0 and `run_active_o` is low.
- R2: A line whose trigger-mode bit is 1 pends on a rising edge of its request. A line whose trigger-mode bit is 0 pends on every clock edge at which its request is high. A line pended at an edge is offered (if eligible) from that edge on.
- R3: While `gmask_i` is high, `irq_valid_o` is low and no handler can be entered, yet requests still become pending. In the cycle `gmask_i` falls, the best pending line is offered.
- R4: Among eligible pending lines the one with the numerically largest priority is offered. On equal priority, the lowest line index wins.
- R5: With a handler running, a line is offered only if its priority is strictly greater than `run_prio_o`. Lines with equal or lower priority stay pending.
- R6: An acknowledge of an offered vector pushes that line's priority. `nest_depth_o` rises by one and `run_prio_o` takes the new priority. An end-of-handler pulse pops one level and restores the preempted priority.
- R7: Any number of repeated requests on a line that is already pending merge into one pending event, which is dispatched once.
- R8: Acknowledging a line clears its pending bit. If the request is present at the acknowledge edge (a level line still asserted), the bit is set again and the line is offered again later.
- R9: A disabled line (`line_en_i` bit 0) may pend but is never offered. Once enabled, it is offered without a new request.
- R10: An acknowledge while `irq_valid_o` is low has no effect. An end-of-handler pulse with no handler running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_LINES | Request lines |
| trig_mode_i | input | N_LINES | Per line: 1 = rising edge, 0 = level |
| line_en_i | input | N_LINES | Per-line enable |
| line_prio_i | input | N_LINES*PRIO_W | Per-line priority, line k in bits [k*PRIO_W +: PRIO_W], larger is more urgent |
| gmask_i | input | 1 | Global mask (critical section) |
| ack_i | input | 1 | Core accepts the offered vector |
| eoi_i | input | 1 | Core closes the innermost handler |
| irq_valid_o | output | 1 | A vector is offered |
| irq_vec_o | output | IDX_W | Index of the offered line |
| run_prio_o | output | PRIO_W | Priority of the innermost running handler (0 when idle) |
| run_active_o | output | 1 | At least one handler is running |
| nest_depth_o | output | DEPTH_W | Number of handlers on the stack |

## Verification
The hardest state to reach is a stack holding several handlers while lower- and equal-priority lines are still pending behind them. Reaching it needs a request to arrive after a handler has been entered. The stimulus enters a low-priority handler first and then raises a more urgent line, which nests. It then raises a mid-priority line, which must wait until the inner handler closes and must then preempt the outer one. A separate sequence fills the pending set under the mask with two equal-priority lines, so that both the tie rule and the strict-preemption rule are exercised as the backlog drains.

// File: rtl/pnic_pkg.sv
package pnic_pkg;
    // stack operation chosen by the top each cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    localparam logic TRIG_LEVEL = 1'b0;
    localparam logic TRIG_EDGE  = 1'b1;
endpackage

// File: rtl/pnic_pending.sv
module pnic_pending #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic [N_LINES-1:0] edge_sel_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pend_o
);
    import pnic_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] req_prev;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [N_LINES-1:0] set_ev;

    // per-line capture event: edge or level
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_comb begin
            if (edge_sel_i[g] == TRIG_EDGE)
                set_ev[g] = req_i[g] & ~st_q.req_prev[g];
            else
                set_ev[g] = req_i[g];
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req_i;
        // a capture in the same cycle as the clear wins
        st_d.pend     = (st_q.pend & ~clr_i) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/pnic_arbiter.sv
module pnic_arbiter #(
    parameter int N_LINES = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0]        cand_i,
    input  logic [N_LINES*PRIO_W-1:0] prio_i,
    output logic                      any_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    logic              any_w;
    logic [IDX_W-1:0]  idx_w;
    logic [PRIO_W-1:0] best_w;

    // ascending scan with strict compare: lowest index wins a tie
    always_comb begin
        any_w  = 1'b0;
        idx_w  = '0;
        best_w = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (cand_i[i] && (!any_w || prio_i[i*PRIO_W +: PRIO_W] > best_w)) begin
                any_w  = 1'b1;
                idx_w  = IDX_W'(i);
                best_w = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assign any_o  = any_w;
    assign idx_o  = idx_w;
    assign prio_o = best_w;
endmodule

// File: rtl/pnic_stack.sv
module pnic_stack #(
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pnic_pkg::stk_op_e     op_i,
    input  logic [PRIO_W-1:0]     push_prio_i,
    output logic [DEPTH_W-1:0]    depth_o,
    output logic [PRIO_W-1:0]     top_o,
    output logic                  empty_o,
    output logic                  full_o
);
    import pnic_pkg::*;

    typedef struct packed {
        logic [STACK_DEPTH-1:0][PRIO_W-1:0] slot;
        logic [DEPTH_W-1:0]                 depth;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [PRIO_W-1:0] top_w;

    always_comb begin
        top_w = '0;
        for (int i = 0; i < STACK_DEPTH; i++)
            if (DEPTH_W'(i + 1) == st_q.depth) top_w = st_q.slot[i];
    end

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            STK_PUSH: begin
                if (st_q.depth != DEPTH_W'(STACK_DEPTH)) begin
                    for (int i = 0; i < STACK_DEPTH; i++)
                        if (DEPTH_W'(i) == st_q.depth) st_d.slot[i] = push_prio_i;
                    st_d.depth = st_q.depth + DEPTH_W'(1);
                end
            end
            STK_POP: begin
                if (st_q.depth != '0) st_d.depth = st_q.depth - DEPTH_W'(1);
            end
            STK_SWAP: begin
                // close innermost and enter a new one in the same cycle
                for (int i = 0; i < STACK_DEPTH; i++)
                    if (DEPTH_W'(i + 1) == st_q.depth) st_d.slot[i] = push_prio_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth_o = st_q.depth;
    assign top_o   = top_w;
    assign empty_o = (st_q.depth == '0);
    assign full_o  = (st_q.depth == DEPTH_W'(STACK_DEPTH));
endmodule

// File: rtl/prio_nest_irq_ctrl.sv
module prio_nest_irq_ctrl #(
    parameter int N_LINES     = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_i,
    input  logic [N_LINES-1:0]        trig_mode_i,
    input  logic [N_LINES-1:0]        line_en_i,
    input  logic [N_LINES*PRIO_W-1:0] line_prio_i,
    input  logic                      gmask_i,
    input  logic                      ack_i,
    input  logic                      eoi_i,
    output logic                      irq_valid_o,
    output logic [IDX_W-1:0]          irq_vec_o,
    output logic [PRIO_W-1:0]         run_prio_o,
    output logic                      run_active_o,
    output logic [DEPTH_W-1:0]        nest_depth_o
);
    import pnic_pkg::*;

    logic [N_LINES-1:0] pend, cand, clr;
    logic               any_best;
    logic [IDX_W-1:0]   best_idx;
    logic [PRIO_W-1:0]  best_prio, top_prio;
    logic               stk_empty, stk_full;
    logic               offer, take, close;
    stk_op_e            op;

    pnic_pending #(.N_LINES(N_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(irq_i), .edge_sel_i(trig_mode_i),
        .clr_i(clr), .pend_o(pend)
    );

    assign cand = pend & line_en_i;

    pnic_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
        .cand_i(cand), .prio_i(line_prio_i), .any_o(any_best),
        .idx_o(best_idx), .prio_o(best_prio)
    );

    // offer only when unmasked, room to nest, and strictly above the runner
    always_comb begin
        offer = !gmask_i && any_best && !stk_full &&
                (stk_empty || (best_prio > top_prio));
        take  = ack_i && offer;
        close = eoi_i && !stk_empty;
        unique case ({take, close})
            2'b10:   op = STK_PUSH;
            2'b01:   op = STK_POP;
            2'b11:   op = STK_SWAP;
            default: op = STK_HOLD;
        endcase
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_clr
        assign clr[g] = take && (best_idx == IDX_W'(g));
    end

    pnic_stack #(.PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .op_i(op), .push_prio_i(best_prio),
        .depth_o(nest_depth_o), .top_o(top_prio), .empty_o(stk_empty),
        .full_o(stk_full)
    );

    assign irq_valid_o  = offer;
    assign irq_vec_o    = best_idx;
    assign run_prio_o   = top_prio;
    assign run_active_o = !stk_empty;
endmodule

// File: rtl/pnic_checker.sv
module pnic_checker #(
    parameter int N_LINES     = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_LINES-1:0]        line_en_i,
    input logic [N_LINES*PRIO_W-1:0] line_prio_i,
    input logic                      gmask_i,
    input logic                      ack_i,
    input logic                      eoi_i,
    input logic                      irq_valid_o,
    input logic [IDX_W-1:0]          irq_vec_o,
    input logic [PRIO_W-1:0]         run_prio_o,
    input logic                      run_active_o,
    input logic [DEPTH_W-1:0]        nest_depth_o
);
    assert_mask_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask_i && !eoi_i) |=> nest_depth_o == $past(nest_depth_o));

    assert_preempt_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && run_active_o) |->
            (line_prio_i[irq_vec_o*PRIO_W +: PRIO_W] > run_prio_o));

    assert_ack_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o && !eoi_i) |=>
            (nest_depth_o == $past(nest_depth_o) + DEPTH_W'(1)) &&
            (run_prio_o == $past(line_prio_i[irq_vec_o*PRIO_W +: PRIO_W])));

    assert_eoi_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && run_active_o) |=>
            nest_depth_o == $past(nest_depth_o) - DEPTH_W'(1));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth_o <= DEPTH_W'(STACK_DEPTH));

    assert_enabled_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> line_en_i[irq_vec_o]);

    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_valid_o && !eoi_i) |=> nest_depth_o == $past(nest_depth_o));
endmodule

bind prio_nest_irq_ctrl pnic_checker #(
    .N_LINES(N_LINES), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_en_i(line_en_i), .line_prio_i(line_prio_i),
    .gmask_i(gmask_i), .ack_i(ack_i), .eoi_i(eoi_i), .irq_valid_o(irq_valid_o),
    .irq_vec_o(irq_vec_o), .run_prio_o(run_prio_o), .run_active_o(run_active_o),
    .nest_depth_o(nest_depth_o)
);

// File: tb/tb_prio_nest_irq_ctrl.sv
module tb_prio_nest_irq_ctrl;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int SD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic [N-1:0]  trig = '1;
    logic [N-1:0]  en = '1;
    logic [N*PW-1:0] prio;
    logic          gmask = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic          valid, active;
    logic [2:0]    vec;
    logic [PW-1:0] rprio;
    logic [3:0]    depth;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // line priorities: 0:1 1:2 2:3 3:2 4:5 5:6 6:6 7:4
    initial prio = {3'd4, 3'd6, 3'd6, 3'd5, 3'd2, 3'd3, 3'd2, 3'd1};

    prio_nest_irq_ctrl #(.N_LINES(N), .PRIO_W(PW), .STACK_DEPTH(SD)) dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .trig_mode_i(trig), .line_en_i(en),
        .line_prio_i(prio), .gmask_i(gmask), .ack_i(ack), .eoi_i(eoi),
        .irq_valid_o(valid), .irq_vec_o(vec), .run_prio_o(rprio),
        .run_active_o(active), .nest_depth_o(depth)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic offered(input string req, input int line);
        chk(req, "valid", int'(valid), 1);
        chk(req, "vector", int'(vec), line);
    endtask

    task automatic pulse(input int line);
        irq[line] = 1'b1;
        @(negedge clk);
        irq[line] = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "valid", int'(valid), 0);
        chk("R1", "depth", int'(depth), 0);
        chk("R1", "active", int'(active), 0);
    endtask

    task automatic t_basic();
        pulse(3);
        offered("R2", 3);
        do_ack();
        chk("R6", "depth after ack", int'(depth), 1);
        chk("R6", "run prio", int'(rprio), 2);
        chk("R8", "pending cleared", int'(valid), 0);
        do_eoi();
        chk("R6", "depth after eoi", int'(depth), 0);
    endtask

    task automatic t_mask();
        gmask = 1'b1;
        pulse(1); pulse(5); pulse(6); pulse(2);
        repeat (3) @(negedge clk);
        chk("R3", "masked valid", int'(valid), 0);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk("R3", "no entry under mask", int'(depth), 0);
        gmask = 1'b0; #1;
        offered("R3", 5);             // tie 5/6 at prio 6, lower index first (R4)
        @(negedge clk);
        do_ack();
        chk("R5", "equal prio waits", int'(valid), 0);
        do_eoi();
        offered("R4", 6);
        do_ack(); do_eoi();
        offered("R4", 2);
        do_ack(); do_eoi();
        offered("R4", 1);
        do_ack(); do_eoi();
        chk("R4", "backlog drained", int'(valid), 0);
    endtask

    task automatic t_nest();
        pulse(0); do_ack();
        chk("R6", "outer run prio", int'(rprio), 1);
        pulse(4);
        offered("R5", 4);
        do_ack();
        chk("R6", "nested depth", int'(depth), 2);
        chk("R6", "inner run prio", int'(rprio), 5);
        pulse(2);
        chk("R5", "lower waits", int'(valid), 0);
        do_eoi();
        chk("R6", "restored prio", int'(rprio), 1);
        offered("R5", 2);
        do_ack();
        chk("R6", "renested depth", int'(depth), 2);
        do_eoi(); do_eoi();
        chk("R6", "all closed", int'(depth), 0);
    endtask

    task automatic t_merge();
        gmask = 1'b1;
        pulse(7); @(negedge clk); pulse(7); @(negedge clk); pulse(7);
        gmask = 1'b0; #1;
        offered("R7", 7);
        @(negedge clk);
        do_ack(); do_eoi();
        chk("R7", "single dispatch", int'(valid), 0);
    endtask

    task automatic t_level();
        trig[3] = 1'b0;
        irq[3] = 1'b1;
        @(negedge clk);
        offered("R2", 3);
        do_ack();                      // source still high at the acknowledge
        chk("R8", "depth", int'(depth), 1);
        chk("R5", "equal re-pend waits", int'(valid), 0);
        irq[3] = 1'b0;
        do_eoi();
        offered("R8", 3);
        do_ack(); do_eoi();
        chk("R8", "cleared after low", int'(valid), 0);
        trig[3] = 1'b1;
    endtask

    task automatic t_disable();
        en[6] = 1'b0;
        pulse(6);
        repeat (2) @(negedge clk);
        chk("R9", "disabled not offered", int'(valid), 0);
        en[6] = 1'b1; #1;
        offered("R9", 6);
        @(negedge clk);
        do_ack(); do_eoi();
    endtask

    task automatic t_ignore();
        do_ack();
        chk("R10", "stray ack", int'(depth), 0);
        do_eoi();
        chk("R10", "stray eoi", int'(depth), 0);
        pulse(4);
        offered("R10", 4);
        do_ack();
        chk("R10", "normal after stray", int'(depth), 1);
        do_eoi();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mask();
        t_nest();
        t_merge();
        t_level();
        t_disable();
        t_ignore();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule